// File: doc/BRIEF.md
# Byte-Lane Write-Masked Pipelined SRAM

This block is a synchronous single-port memory. Its word is made of byte lanes, and each lane holds eight data bits and one parity bit. On every rising clock edge the block captures the select, the address, the write data and the write controls. A write is then posted into a one-entry buffer and committed to the storage array one edge later.

There are two ways to write. A global write control stores the whole word. Per-lane enables store selected lanes, but only while a master lane-write enable is active. If neither path is active, the cycle is a read. Read data reaches the output through a pipeline register. A read that follows a write to the same address gets the fresh data from the posted buffer, merged lane by lane with the stored word.

The data bus is split into an input, an output and a drive enable for the pad. The drive enable rises only for a selected read slot while the asynchronous output enable is active.

Top module: `bwsram`

## Requirements
- R1: Lane k occupies word bits [9k+8:9k], and bit 9k+8 is that lane's parity bit. A lane-enabled write changes exactly those nine bits of the addressed word and leaves every other lane unchanged.
- R2: Per-lane enables `lane_wr_n[k]` (active low) store anything only while `bytes_en_n` is low. With both `all_wr_n` and `bytes_en_n` high the cycle is a read and the array is not modified.
- R3: While `all_wr_n` is low at a selected edge, every lane is written, whatever the values of `bytes_en_n` and `lane_wr_n`.
- R4: Address, data, select and write controls are taken only at the rising edge. A write stores the values present at its edge, and input changes between edges have no effect.
- R5: Read data registered at edge N appears on `dq_o` after edge N+1.
- R6: A read registered at the edge right after a write to the same address returns the written lanes merged with the unchanged stored lanes. This also holds after two back-to-back writes to that address.
- R7: `dq_drive` is high only while `oe_n` is low and the output slot holds a selected read. It follows `oe_n` without a clock edge, and it is low in the slot after a write.
- R8: With `sel_n` high at an edge, nothing is written, and `dq_drive` stays low in the output slot of that edge.
- R9: While `rst_n` is low, `dq_drive` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the pipeline registers |
| sel_n | input | 1 | Active-low device select, registered with the address |
| addr | input | AW | Word address |
| all_wr_n | input | 1 | Active-low whole-word write |
| bytes_en_n | input | 1 | Active-low master enable for the per-lane enables |
| lane_wr_n | input | LANES | Active-low per-lane write enables |
| oe_n | input | 1 | Asynchronous active-low output enable |
| dq_i | input | W | Write data from the bus |
| dq_o | output | W | Read data toward the bus |
| dq_drive | output | 1 | Pad drive enable for `dq_o` |

## Verification
The hardest case to reach from the ports is a read that must take its data from the posted-write buffer while the array still holds the old word. This needs a write followed by a read of the same address on the very next edge. The bench reaches it by changing the controls at the falling edge that lies between the two. It then stacks two partial writes to one address before the read, so that one lane must come from the buffer, one from the freshly committed array and the rest from older contents. The asynchronous output enable is toggled between clock edges to show that the drive enable follows it without a clock.

// File: rtl/bwsram_pkg.sv
package bwsram_pkg;
  // Bits per byte lane: eight data bits plus one parity bit on top.
  localparam int LANE_W = 9;
endpackage

// File: rtl/bwsram_capture.sv
module bwsram_capture #(
  parameter int LANES = 4,
  parameter int AW    = 4,
  localparam int W    = LANES * bwsram_pkg::LANE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_n,
  input  logic [AW-1:0]    addr,
  input  logic             all_wr_n,
  input  logic             bytes_en_n,
  input  logic [LANES-1:0] lane_wr_n,
  input  logic [W-1:0]     dq_i,
  output logic [AW-1:0]    addr_q,
  output logic [W-1:0]     data_q,
  output logic [LANES-1:0] mask_q,
  output logic             is_wr,
  output logic             is_rd
);
  logic act_q;

  // Lane write mask: the global write wins, otherwise lanes need the master enable.
  function automatic logic [LANES-1:0] lane_mask(input logic g_n, input logic b_n,
                                                 input logic [LANES-1:0] l_n);
    if (!g_n)      return '1;
    else if (!b_n) return ~l_n;
    else           return '0;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
      mask_q <= '0;
    end else begin
      act_q  <= ~sel_n;
      addr_q <= addr;
      data_q <= dq_i;
      mask_q <= sel_n ? '0 : lane_mask(all_wr_n, bytes_en_n, lane_wr_n);
    end
  end

  assign is_wr = act_q & (|mask_q);
  assign is_rd = act_q & ~(|mask_q);

  assert_global_all_lanes_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_n && !all_wr_n) |=> (is_wr && mask_q == '1));

  assert_lanes_need_master_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_n && all_wr_n && bytes_en_n) |=> (is_rd && mask_q == '0));
endmodule

// File: rtl/bwsram_wbuf.sv
module bwsram_wbuf #(
  parameter int LANES = 4,
  parameter int AW    = 4,
  localparam int W    = LANES * bwsram_pkg::LANE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             is_wr,
  input  logic [AW-1:0]    addr_q,
  input  logic [W-1:0]     data_q,
  input  logic [LANES-1:0] mask_q,
  output logic             pend_valid,
  output logic [AW-1:0]    pend_addr,
  output logic [W-1:0]     pend_data,
  output logic [LANES-1:0] pend_lanes,
  output logic [W-1:0]     pend_bits
);
  // Expands one enable per lane into one enable per bit.
  function automatic logic [W-1:0] spread(input logic [LANES-1:0] m);
    logic [W-1:0] r;
    for (int k = 0; k < LANES; k++)
      r[k*bwsram_pkg::LANE_W +: bwsram_pkg::LANE_W] = {bwsram_pkg::LANE_W{m[k]}};
    return r;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_valid <= 1'b0;
      pend_addr  <= '0;
      pend_data  <= '0;
      pend_lanes <= '0;
    end else begin
      pend_valid <= is_wr;
      if (is_wr) begin
        pend_addr  <= addr_q;
        pend_data  <= data_q;
        pend_lanes <= mask_q;
      end
    end
  end

  assign pend_bits = spread(pend_lanes);
endmodule

// File: rtl/bwsram_array.sv
module bwsram_array #(
  parameter int LANES = 4,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int W    = LANES * bwsram_pkg::LANE_W
) (
  input  logic             clk,
  input  logic             commit,
  input  logic [AW-1:0]    waddr,
  input  logic [W-1:0]     wdata,
  input  logic [LANES-1:0] wlanes,
  input  logic [AW-1:0]    raddr,
  output logic [W-1:0]     rdata
);
  localparam int LW = bwsram_pkg::LANE_W;

  // One storage column per lane, each with its own write enable.
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LW-1:0] col [DEPTH];
    always_ff @(posedge clk) begin
      if (commit && wlanes[g]) col[waddr] <= wdata[g*LW +: LW];
    end
    assign rdata[g*LW +: LW] = col[raddr];
  end
endmodule

// File: rtl/bwsram_rdpipe.sv
module bwsram_rdpipe #(
  parameter int LANES = 4,
  parameter int AW    = 4,
  localparam int W    = LANES * bwsram_pkg::LANE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          is_rd,
  input  logic [AW-1:0] raddr,
  input  logic [W-1:0]  rdata,
  input  logic          pend_valid,
  input  logic [AW-1:0] pend_addr,
  input  logic [W-1:0]  pend_data,
  input  logic [W-1:0]  pend_bits,
  input  logic          oe_n,
  output logic [W-1:0]  dq_o,
  output logic          dq_drive
);
  logic         hit;
  logic [W-1:0] merged;
  logic         out_sel_q;

  // Written lanes come from the posted write, the rest from storage.
  function automatic logic [W-1:0] lane_merge(input logic [W-1:0] old_w,
                                              input logic [W-1:0] new_w,
                                              input logic [W-1:0] bits);
    return (old_w & ~bits) | (new_w & bits);
  endfunction

  assign hit    = pend_valid && (pend_addr == raddr);
  assign merged = hit ? lane_merge(rdata, pend_data, pend_bits) : rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_sel_q <= 1'b0;
      dq_o      <= '0;
    end else begin
      out_sel_q <= is_rd;
      if (is_rd) dq_o <= merged;
    end
  end

  assign dq_drive = out_sel_q & ~oe_n;

  assert_bypass_fresh_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (is_rd && hit) |=> ((dq_o & $past(pend_bits)) == ($past(pend_data) & $past(pend_bits))));
endmodule

// File: rtl/bwsram.sv
module bwsram #(
  parameter int LANES = 4,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int W    = LANES * bwsram_pkg::LANE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_n,
  input  logic [AW-1:0]    addr,
  input  logic             all_wr_n,
  input  logic             bytes_en_n,
  input  logic [LANES-1:0] lane_wr_n,
  input  logic             oe_n,
  input  logic [W-1:0]     dq_i,
  output logic [W-1:0]     dq_o,
  output logic             dq_drive
);
  logic [AW-1:0]    addr_q, pend_addr;
  logic [W-1:0]     data_q, pend_data, pend_bits, rdata;
  logic [LANES-1:0] mask_q, pend_lanes;
  logic             is_wr, is_rd, pend_valid;

  bwsram_capture #(.LANES(LANES), .AW(AW)) u_capture (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .addr(addr), .all_wr_n(all_wr_n),
    .bytes_en_n(bytes_en_n), .lane_wr_n(lane_wr_n), .dq_i(dq_i),
    .addr_q(addr_q), .data_q(data_q), .mask_q(mask_q), .is_wr(is_wr), .is_rd(is_rd));

  bwsram_wbuf #(.LANES(LANES), .AW(AW)) u_wbuf (
    .clk(clk), .rst_n(rst_n), .is_wr(is_wr), .addr_q(addr_q), .data_q(data_q),
    .mask_q(mask_q), .pend_valid(pend_valid), .pend_addr(pend_addr),
    .pend_data(pend_data), .pend_lanes(pend_lanes), .pend_bits(pend_bits));

  bwsram_array #(.LANES(LANES), .DEPTH(DEPTH)) u_array (
    .clk(clk), .commit(pend_valid), .waddr(pend_addr), .wdata(pend_data),
    .wlanes(pend_lanes), .raddr(addr_q), .rdata(rdata));

  bwsram_rdpipe #(.LANES(LANES), .AW(AW)) u_rdpipe (
    .clk(clk), .rst_n(rst_n), .is_rd(is_rd), .raddr(addr_q), .rdata(rdata),
    .pend_valid(pend_valid), .pend_addr(pend_addr), .pend_data(pend_data),
    .pend_bits(pend_bits), .oe_n(oe_n), .dq_o(dq_o), .dq_drive(dq_drive));

  assert_read_no_commit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_n && all_wr_n && bytes_en_n) |=> ##1 !pend_valid);

  assert_deselect_dark_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sel_n |=> ##1 (!dq_drive && !pend_valid));

  assert_write_slot_dark_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_n && !all_wr_n) |=> ##1 !dq_drive);
endmodule

// File: tb/bwsram_bench.sv
`timescale 1ns/1ps
module bwsram_bench;
  localparam int LANES = 4;
  localparam int DEPTH = 16;
  localparam int AW = 4;
  localparam int W = 36;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sel_n = 1'b1, all_wr_n = 1'b1, bytes_en_n = 1'b1, oe_n = 1'b0;
  logic [LANES-1:0] lane_wr_n = '1;
  logic [AW-1:0] addr = '0;
  logic [W-1:0] dq_i = '0;
  logic [W-1:0] dq_o;
  logic dq_drive;
  int checks = 0, errors = 0;
  logic [W-1:0] model [DEPTH];

  always #2 clk = ~clk;

  bwsram #(.LANES(LANES), .DEPTH(DEPTH)) u_bwsram (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .addr(addr), .all_wr_n(all_wr_n),
    .bytes_en_n(bytes_en_n), .lane_wr_n(lane_wr_n), .oe_n(oe_n), .dq_i(dq_i),
    .dq_o(dq_o), .dq_drive(dq_drive));

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic idle();
    sel_n = 1'b1; all_wr_n = 1'b1; bytes_en_n = 1'b1; lane_wr_n = '1;
  endtask

  // Bench-side model of the lane write rule.
  task automatic model_write(input logic [AW-1:0] a, input logic [W-1:0] d,
                             input logic g_n, input logic b_n, input logic [LANES-1:0] l_n);
    for (int k = 0; k < LANES; k++)
      if (g_n == 1'b0 || (b_n == 1'b0 && l_n[k] == 1'b0)) model[a][k*9 +: 9] = d[k*9 +: 9];
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [W-1:0] d,
                    input logic g_n, input logic b_n, input logic [LANES-1:0] l_n);
    sel_n = 1'b0; addr = a; dq_i = d; all_wr_n = g_n; bytes_en_n = b_n; lane_wr_n = l_n;
    model_write(a, d, g_n, b_n, l_n);
    tick();
    idle();
  endtask

  task automatic rd_chk(input logic [AW-1:0] a, input string req);
    sel_n = 1'b0; addr = a; all_wr_n = 1'b1; bytes_en_n = 1'b1; lane_wr_n = '1;
    tick();
    idle();
    tick();
    chk(req, dq_o, model[a]);
    chk({req, " drive"}, {35'd0, dq_drive}, 36'd1);
  endtask

  task automatic t_reset();
    chk("R9 reset drive", {35'd0, dq_drive}, 36'd0);
    rst_n = 1'b1;
    tick();
    chk("R9 idle after reset", {35'd0, dq_drive}, 36'd0);
  endtask

  task automatic t_fill();
    for (int i = 0; i < DEPTH; i++) wr(i[AW-1:0], {4{5'h0, i[3:0]}} ^ 36'h5A5A5A5A5, 1'b0, 1'b1, '1);
    tick();
    rd_chk(4'd3, "R5 R3 full write read");
    rd_chk(4'd12, "R5 second address");
  endtask

  task automatic t_lane_write();
    wr(4'd5, 36'hFFFFFFFFF, 1'b1, 1'b0, 4'b1101);  // lane 1 only, parity bit 17 included
    tick();
    rd_chk(4'd5, "R1 single lane");
    wr(4'd6, 36'h000000000, 1'b1, 1'b0, 4'b0110);  // lanes 0 and 3
    tick();
    rd_chk(4'd6, "R1 two lanes");
  endtask

  task automatic t_no_master();
    wr(4'd7, 36'h123456789, 1'b1, 1'b1, 4'b0000);  // lanes asked, master off
    tick();
    rd_chk(4'd7, "R2 lanes without master");
  endtask

  task automatic t_global();
    wr(4'd8, 36'hABCDEF012, 1'b0, 1'b0, 4'b1110);
    tick();
    rd_chk(4'd8, "R3 global overrides lanes");
  endtask

  task automatic t_registered();
    wr(4'd9, 36'h111111111, 1'b0, 1'b1, '1);
    dq_i = 36'h999999999; addr = 4'd9;  // between edges with no write requested
    tick();
    rd_chk(4'd9, "R4 edge-captured data");
  endtask

  task automatic t_passthrough();
    wr(4'd10, 36'h0F0F0F0F0, 1'b0, 1'b1, '1);
    rd_chk(4'd10, "R6 full write then read");
    wr(4'd11, 36'h1FF1FF1FF, 1'b1, 1'b0, 4'b1011);
    rd_chk(4'd11, "R6 partial merge");
    wr(4'd4, 36'h100000000, 1'b1, 1'b0, 4'b0111);
    wr(4'd4, 36'h000000155, 1'b1, 1'b0, 4'b1110);
    rd_chk(4'd4, "R6 two writes then read");
  endtask

  task automatic t_oe();
    rd_chk(4'd3, "R7 read before toggle");
    oe_n = 1'b1; #0.5;
    chk("R7 oe off", {35'd0, dq_drive}, 36'd0);
    oe_n = 1'b0; #0.5;
    chk("R7 oe on", {35'd0, dq_drive}, 36'd1);
    wr(4'd13, 36'h222222222, 1'b0, 1'b1, '1);
    tick();
    chk("R7 write slot dark", {35'd0, dq_drive}, 36'd0);
  endtask

  task automatic t_deselect();
    sel_n = 1'b1; addr = 4'd2; dq_i = 36'h333333333; all_wr_n = 1'b0;
    tick();
    idle();
    tick();
    chk("R8 deselected slot dark", {35'd0, dq_drive}, 36'd0);
    rd_chk(4'd2, "R8 no write when deselected");
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) model[i] = '0;
    tick();
    t_reset();
    t_fill();
    t_lane_write();
    t_no_master();
    t_global();
    t_registered();
    t_passthrough();
    t_oe();
    t_deselect();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule